// File: doc/BRIEF.md
# Multi-Channel DMA Descriptor Fetch Sequencer

This block keeps the trigger and control state for a set of DMA channels (six by default). From that state it decides where the next descriptor for a channel should be read from. Software sets a channel's head (start) descriptor address, its enable and pause bits, and its trigger and one-shot retrigger bits through a simple register write port.

The descriptor engine asks to start a channel on a request port. It receives a combinational answer in the same cycle: either "not started", or "started", with the fetch address and a flag that says whether the address is the head address. When the engine has fetched and checked a descriptor, it reports back on a result port. The report carries the descriptor's next pointer, an error flag and an end flag for last descriptor or last of frame. The sequencer uses it to update the channel's link pointer and its sticky "finished" flag.

A channel that is finished, or that has a pending retrigger, restarts at its head address. Otherwise it follows the link pointer.

All ports are plain control and status pins. The start request is answered in the cycle it is presented and is never back-pressured. Results are taken on every cycle in which `res_valid` is high.

Top module: `dma_fetch_seq`

## Requirements
- R1: After reset every channel is finished, and no channel is triggered, enabled or paused. The head, link and control values are zero, and a start request is refused.
- R2: A register write of kind 0 (global) ORs bit n of the data into the trigger of channel n, and bit NUM_CH+n into the retrigger of channel n. Bits that are already set are never cleared by a global write, and the channel field is ignored.
- R3: A register write of kind 1 (control) to channel n stores data bit 0 as enable and data bit 1 as pause, and clears the trigger of channel n.
- R4: A start request is refused (start_ok low) in the same cycle when any of these holds: the channel number is NUM_CH or higher, the channel is not triggered, it is not enabled, or it is paused. A refused request changes no state.
- R5: An accepted start on a finished channel returns the head address with start_from_head high. It clears the finished flag and leaves the retrigger bit untouched.
- R6: An accepted start on a channel that is not finished but has its retrigger set returns the head address and clears the retrigger, so the next start follows the link pointer.
- R7: An accepted start on a channel that is neither finished nor retriggered returns the link address with start_from_head low. Register writes of kind 3 (link) are ignored.
- R8: A result with res_err low loads res_next into the channel's link pointer. A result with res_err or res_last high sets the channel's finished flag. An errored result leaves the link pointer unchanged.
- R9: A register write of kind 2 (head) to channel n replaces the full-width head address of channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_kind | input | 2 | 0 global, 1 control, 2 head, 3 link |
| reg_ch | input | CH_W | Target channel for kinds 1 to 3 |
| reg_wdata | input | AW | Write data |
| start_req | input | 1 | Start request |
| start_ch | input | CH_W | Channel to start |
| start_ok | output | 1 | Request accepted (same cycle) |
| start_from_head | output | 1 | Fetch address is the head address |
| fetch_addr | output | AW | Descriptor fetch address, zero when refused |
| res_valid | input | 1 | Descriptor result strobe |
| res_ch | input | CH_W | Channel of the result |
| res_err | input | 1 | Descriptor error |
| res_last | input | 1 | Descriptor is last or last of frame |
| res_next | input | AW | Next pointer from the descriptor |

## Verification
The bench builds the block with its default parameters: six channels, 32 low address bits and 16 extension bits, so a 48-bit address. It uses a three-bit channel field. With these values, channels 6 and 7 exist on the channel field but are out of range, so the refusal path for illegal channels can be reached. The retrigger bits sit at positions 6 to 11, apart from the trigger bits. The highest channel is exercised with both bits set at once, and an all-ones head write covers the full 48-bit path.

// File: rtl/dma_fetch_seq_pkg.sv
package dma_fetch_seq_pkg;
  typedef enum logic [1:0] {
    KIND_GLOBAL = 2'd0,
    KIND_CTRL   = 2'd1,
    KIND_HEAD   = 2'd2,
    KIND_LINK   = 2'd3
  } reg_kind_e;

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_PAUSE_BIT = 1;
endpackage

// File: rtl/dma_fetch_trig.sv
module dma_fetch_trig #(
  parameter int NUM_CH = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                glb_wr,
  input  logic [2*NUM_CH-1:0] glb_bits,
  input  logic [NUM_CH-1:0]   trig_clr,
  input  logic [NUM_CH-1:0]   retrig_clr,
  output logic [NUM_CH-1:0]   trig,
  output logic [NUM_CH-1:0]   retrig
);
  logic [NUM_CH-1:0] set_trig, set_retrig;

  // Sets from a global write win over same-cycle clears.
  assign set_trig   = glb_wr ? glb_bits[NUM_CH-1:0]        : '0;
  assign set_retrig = glb_wr ? glb_bits[2*NUM_CH-1:NUM_CH] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig   <= '0;
      retrig <= '0;
    end else begin
      trig   <= (trig & ~trig_clr) | set_trig;
      retrig <= (retrig & ~retrig_clr) | set_retrig;
    end
  end

  // R3: a control write drops the channel trigger
  p_ctl_drops_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_clr != '0 && !glb_wr) |=> ((trig & $past(trig_clr)) == '0));

  // R6: a consumed retrigger is gone on the next cycle
  p_retrig_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig_clr != '0 && !glb_wr) |=> ((retrig & $past(retrig_clr)) == '0));

  // R2: without a global write no trigger bit can appear
  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_wr |=> ((trig & ~$past(trig)) == '0));
endmodule

// File: rtl/dma_fetch_chan.sv
module dma_fetch_chan
  import dma_fetch_seq_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [1:0]    ctl_bits,
  input  logic          head_wr,
  input  logic [AW-1:0] head_data,
  input  logic          res_hit,
  input  logic          res_err,
  input  logic          res_last,
  input  logic [AW-1:0] res_next,
  input  logic          fin_clr,
  output logic          en,
  output logic          pause,
  output logic [AW-1:0] head,
  output logic [AW-1:0] link,
  output logic          fin
);
  logic res_end, res_load;

  assign res_end  = res_hit && (res_err || res_last);
  assign res_load = res_hit && !res_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      pause <= 1'b0;
      head  <= '0;
      link  <= '0;
      fin   <= 1'b1;
    end else begin
      if (ctl_wr) begin
        en    <= ctl_bits[CTL_EN_BIT];
        pause <= ctl_bits[CTL_PAUSE_BIT];
      end
      if (head_wr) head <= head_data;
      if (res_load) link <= res_next;
      if (res_end) fin <= 1'b1;
      else if (fin_clr) fin <= 1'b0;
    end
  end

  // R5: taking the head address clears finished
  p_head_clears_fin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_clr && !res_end) |=> !fin);

  // R8: an ending result marks the channel finished
  p_end_sets_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_end |=> fin);

  // R7: the link pointer moves only on a clean result
  p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_load |=> $stable(link));

  // R3: control bits change only on a control write
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({en, pause}));
endmodule

// File: rtl/dma_fetch_pick.sv
module dma_fetch_pick #(
  parameter int NUM_CH = 6,
  parameter int AW     = 48,
  parameter int CH_W   = 3
) (
  input  logic                       req,
  input  logic [CH_W-1:0]            ch,
  input  logic [NUM_CH-1:0]          trig,
  input  logic [NUM_CH-1:0]          retrig,
  input  logic [NUM_CH-1:0]          en,
  input  logic [NUM_CH-1:0]          pause,
  input  logic [NUM_CH-1:0]          fin,
  input  logic [NUM_CH-1:0][AW-1:0]  head,
  input  logic [NUM_CH-1:0][AW-1:0]  link,
  output logic                       ok,
  output logic                       from_head,
  output logic [AW-1:0]              addr,
  output logic [NUM_CH-1:0]          fin_clr,
  output logic [NUM_CH-1:0]          retrig_clr
);
  always_comb begin
    ok         = 1'b0;
    from_head  = 1'b0;
    addr       = '0;
    fin_clr    = '0;
    retrig_clr = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req && ch == CH_W'(i) && trig[i] && en[i] && !pause[i]) begin
        ok = 1'b1;
        // Finished is examined first; retrigger is only consumed otherwise.
        if (fin[i]) begin
          from_head  = 1'b1;
          fin_clr[i] = 1'b1;
        end else if (retrig[i]) begin
          from_head     = 1'b1;
          retrig_clr[i] = 1'b1;
        end
        addr = from_head ? head[i] : link[i];
      end
    end
  end
endmodule

// File: rtl/dma_fetch_seq.sv
module dma_fetch_seq
  import dma_fetch_seq_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int LO_W   = 32,
  parameter int EXT_W  = 16,
  localparam int AW    = LO_W + EXT_W,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_kind,
  input  logic [CH_W-1:0] reg_ch,
  input  logic [AW-1:0]   reg_wdata,
  input  logic            start_req,
  input  logic [CH_W-1:0] start_ch,
  output logic            start_ok,
  output logic            start_from_head,
  output logic [AW-1:0]   fetch_addr,
  input  logic            res_valid,
  input  logic [CH_W-1:0] res_ch,
  input  logic            res_err,
  input  logic            res_last,
  input  logic [AW-1:0]   res_next
);
  reg_kind_e kind;
  logic glb_wr;
  logic [NUM_CH-1:0] ctl_wr, head_wr, res_hit;
  logic [NUM_CH-1:0] trig, retrig, en, pause, fin, fin_clr, retrig_clr;
  logic [NUM_CH-1:0][AW-1:0] head, link;

  assign kind   = reg_kind_e'(reg_kind);
  assign glb_wr = reg_wr && kind == KIND_GLOBAL;

  dma_fetch_trig #(.NUM_CH(NUM_CH)) trig_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_wr     (glb_wr),
    .glb_bits   (reg_wdata[2*NUM_CH-1:0]),
    .trig_clr   (ctl_wr),
    .retrig_clr (retrig_clr),
    .trig       (trig),
    .retrig     (retrig)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ctl_wr[g]  = reg_wr && kind == KIND_CTRL && reg_ch == CH_W'(g);
    assign head_wr[g] = reg_wr && kind == KIND_HEAD && reg_ch == CH_W'(g);
    assign res_hit[g] = res_valid && res_ch == CH_W'(g);

    dma_fetch_chan #(.AW(AW)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr[g]),
      .ctl_bits  (reg_wdata[1:0]),
      .head_wr   (head_wr[g]),
      .head_data (reg_wdata),
      .res_hit   (res_hit[g]),
      .res_err   (res_err),
      .res_last  (res_last),
      .res_next  (res_next),
      .fin_clr   (fin_clr[g]),
      .en        (en[g]),
      .pause     (pause[g]),
      .head      (head[g]),
      .link      (link[g]),
      .fin       (fin[g])
    );
  end

  dma_fetch_pick #(.NUM_CH(NUM_CH), .AW(AW), .CH_W(CH_W)) pick_i (
    .req        (start_req),
    .ch         (start_ch),
    .trig       (trig),
    .retrig     (retrig),
    .en         (en),
    .pause      (pause),
    .fin        (fin),
    .head       (head),
    .link       (link),
    .ok         (start_ok),
    .from_head  (start_from_head),
    .addr       (fetch_addr),
    .fin_clr    (fin_clr),
    .retrig_clr (retrig_clr)
  );

  // R4: a refused start leaves finished and retrigger state alone
  p_refused_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !start_ok && !res_valid && !reg_wr) |=> ($stable(fin) && $stable(retrig)));

  // R4: no acceptance without a request
  p_no_req_no_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |-> !start_ok);
endmodule

// File: tb/dma_fetch_seq_tb_top.sv
`timescale 1ns/100ps
module dma_fetch_seq_tb_top;
  localparam int AW   = 48;
  localparam int CH_W = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_kind = '0;
  logic [CH_W-1:0] reg_ch = '0;
  logic [AW-1:0]   reg_wdata = '0;
  logic            start_req = 1'b0;
  logic [CH_W-1:0] start_ch = '0;
  logic            start_ok, start_from_head;
  logic [AW-1:0]   fetch_addr;
  logic            res_valid = 1'b0;
  logic [CH_W-1:0] res_ch = '0;
  logic            res_err = 1'b0, res_last = 1'b0;
  logic [AW-1:0]   res_next = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic          ok;
    logic          hd;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  dma_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_kind(reg_kind), .reg_ch(reg_ch), .reg_wdata(reg_wdata),
    .start_req(start_req), .start_ch(start_ch),
    .start_ok(start_ok), .start_from_head(start_from_head), .fetch_addr(fetch_addr),
    .res_valid(res_valid), .res_ch(res_ch), .res_err(res_err),
    .res_last(res_last), .res_next(res_next)
  );

  task automatic wr(input logic [1:0] k, input int ch, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_kind = k; reg_ch = CH_W'(ch); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic result(input int ch, input bit err, input bit last,
                        input logic [AW-1:0] nxt);
    @(negedge clk);
    res_valid = 1'b1; res_ch = CH_W'(ch); res_err = err; res_last = last; res_next = nxt;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic start(input int ch, input bit ok, input bit hd,
                       input logic [AW-1:0] a, input string tag);
    exp_t e;
    e.ok = ok; e.hd = hd; e.a = ok ? a : '0; e.tag = tag;
    @(negedge clk);
    start_req = 1'b1; start_ch = CH_W'(ch);
    expq.push_back(e);
    @(negedge clk);
    start_req = 1'b0;
  endtask

  // Monitor: compares each response in the cycle it is presented
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (start_req) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (start_ok !== e.ok || start_from_head !== e.hd || fetch_addr !== e.a) begin
          fails++;
          $display("FAIL %s: got ok=%0b head=%0b addr=%h, expected ok=%0b head=%0b addr=%h",
                   e.tag, start_ok, start_from_head, fetch_addr, e.ok, e.hd, e.a);
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang, expected finish");
      summary();
    end
  end

  localparam logic [AW-1:0] H0 = 48'h1234_0000_1000;
  localparam logic [AW-1:0] L1 = 48'h00AB_0000_2000;
  localparam logic [AW-1:0] L2 = 48'h0000_0000_3000;
  localparam logic [AW-1:0] H5 = 48'h0000_CAFE_5500;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    start(0, 0, 0, '0, "R1 start refused after reset");
    wr(2'd2, 0, H0);
    wr(2'd1, 0, 48'd1);
    start(0, 0, 0, '0, "R4 enabled but not triggered");
    wr(2'd0, 0, 48'h1);
    start(0, 1, 1, H0, "R5 finished after reset takes head");
    start(0, 1, 0, '0, "R7 follows reset link pointer");
    wr(2'd0, 0, 48'h8);
    start(0, 1, 0, '0, "R2 global write keeps earlier trigger");
    start(3, 0, 0, '0, "R4 triggered channel 3 not enabled");
    result(0, 0, 0, L1);
    start(0, 1, 0, L1, "R8 clean result loads link");
    wr(2'd3, 0, 48'h5555);
    start(0, 1, 0, L1, "R7 link write ignored");
    wr(2'd0, 0, 48'h40);
    start(0, 1, 1, H0, "R6 retrigger restarts at head");
    start(0, 1, 0, L1, "R6 retrigger consumed once");
    result(0, 0, 1, L2);
    start(0, 1, 1, H0, "R8 last result sets finished");
    start(0, 1, 0, L2, "R8 last result also loads link");
    wr(2'd1, 0, 48'd3);
    wr(2'd0, 0, 48'h1);
    start(0, 0, 0, '0, "R4 paused channel refused");
    wr(2'd1, 0, 48'd1);
    start(0, 0, 0, '0, "R3 control write clears trigger");
    wr(2'd0, 0, 48'h1);
    start(0, 1, 0, L2, "R3 enable stored, pause cleared");

    wr(2'd2, 5, H5);
    wr(2'd1, 5, 48'd1);
    wr(2'd0, 0, 48'h820);
    start(5, 1, 1, H5, "R5 finished wins, head address");
    start(5, 1, 1, H5, "R5 retrigger left for next start");
    start(5, 1, 0, '0, "R6 after retrigger link is used");
    result(5, 1, 0, 48'h9999);
    wr(2'd1, 5, 48'd3);
    wr(2'd0, 0, 48'h20);
    start(5, 0, 0, '0, "R4 paused channel 5 refused");
    wr(2'd1, 5, 48'd1);
    wr(2'd0, 0, 48'h20);
    start(5, 1, 1, H5, "R4 refused start kept finished");
    start(5, 1, 0, '0, "R8 errored result does not load link");
    wr(2'd2, 5, {AW{1'b1}});
    wr(2'd0, 0, 48'h800);
    start(5, 1, 1, {AW{1'b1}}, "R9 full width head write");
    start(6, 0, 0, '0, "R4 out of range channel 6");
    start(7, 0, 0, '0, "R4 out of range channel 7");

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule